// File: doc/BRIEF.md
# Dual-Width Accumulator ALU with Flags

This block is the arithmetic and logic datapath of an accumulator machine whose accumulator is 16 bits wide. Each strobe carries an operation code, the accumulator value, a memory operand, a width-mode bit and the current condition flags. One clock edge later the block presents the new accumulator, the value to write back to memory, a write enable, and the updated negative, zero, carry and overflow flags. The operations are add-with-carry, compare, exclusive OR, decrement, rotate left through carry, rotate right through carry and half exchange. Decrement and the two rotates can work on the accumulator or on the memory operand.

In narrow mode only the low half of each value takes part. The upper accumulator byte, and the upper byte of a memory write value, are passed through unchanged. The flags are taken from the low byte only. The half exchange ignores the width mode. Fetching operands, address generation and decimal arithmetic belong to neighbouring blocks.

Top module: `dual_width_alu`

## Requirements
- R1: While reset is asserted and after it is released, every output reads zero until the first strobe.
- R2: A strobe on `valid_in` is answered by results on the next rising edge, and `valid_out` is high for exactly that one cycle. Without a strobe, all outputs keep their values.
- R3: Add-with-carry (op 0), wide mode: the accumulator becomes acc + mem + C modulo 2^16. C is set when the sum exceeds 0xFFFF. V is set when the two addends share a sign and the sum's bit 15 differs from it.
- R4: Add-with-carry, narrow mode: the low byte becomes the 8-bit sum and the high byte is kept. C is set when the sum exceeds 0xFF. V uses bit 7.
- R5: In narrow mode Z reflects only bits 7:0 of the result and N copies bit 7. In wide mode Z covers all 16 bits and N copies bit 15.
- R6: Compare (op 1) leaves the accumulator unchanged. It sets C when acc is greater than or equal to mem at the active width, and takes Z and N from the truncated difference.
- R7: Exclusive OR (op 2) replaces the active part of the accumulator with acc XOR mem and updates Z and N.
- R8: Decrement (op 3) subtracts one with wrap-around at the active width and updates Z and N. C is left alone.
- R9: Rotate left (op 4) shifts C into bit 0, and the active top bit becomes C. Rotate right (op 5) shifts C into the active top bit, and bit 0 becomes C. Z and N follow the result.
- R10: Half exchange (op 6) swaps the two accumulator bytes in either mode and leaves all four flags unchanged.
- R11: V changes only on add-with-carry. Every other op copies the incoming V.
- R12: With `to_mem_in` high, ops 3 to 5 work on `mem_in`. Their result appears on `mem_out` with `mem_we_out` high and the accumulator unchanged. Every other strobe drives `mem_we_out` low and passes `mem_in` to `mem_out`. Op 7 changes neither the accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation strobe |
| op_in | input | 3 | Operation code (0 add, 1 compare, 2 XOR, 3 decrement, 4 rotate left, 5 rotate right, 6 exchange, 7 no-op) |
| narrow_in | input | 1 | 1 selects 8-bit operation |
| to_mem_in | input | 1 | Ops 3 to 5 target the memory operand |
| acc_in | input | 16 | Current accumulator |
| mem_in | input | 16 | Memory operand |
| flags_in | input | 4 | Current flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| valid_out | output | 1 | Result valid, one cycle after the strobe |
| acc_out | output | 16 | New accumulator |
| mem_out | output | 16 | Memory write value |
| mem_we_out | output | 1 | Memory write enable |
| flags_out | output | 4 | New flags, same bit order as flags_in |

## Verification
Every result, flag and write enable sits behind exactly one register, so each one is due on the first rising edge after the strobe. The bench drives a strobe on a falling edge and reads all outputs on the following falling edge, half a cycle after they are registered. It then drops the strobe before the next edge. A separate idle stretch confirms that the outputs hold and that `valid_out` falls one cycle after the strobe ends.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

   typedef enum logic [2:0] {
      OP_ADC = 3'd0,
      OP_CMP = 3'd1,
      OP_EOR = 3'd2,
      OP_DEC = 3'd3,
      OP_ROL = 3'd4,
      OP_ROR = 3'd5,
      OP_XCH = 3'd6,
      OP_NOP = 3'd7
   } alu_op_e;

   // bit 3 N, bit 2 Z, bit 1 C, bit 0 V
   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

endpackage

// File: rtl/dwalu_adder.sv
// Add / subtract core with carry out and signed overflow at either width.
module dwalu_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         sub_i,
   input  logic         narrow_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   localparam int H = W / 2;

   logic [W-1:0] b_eff;
   logic [W:0]   wide_sum;
   logic [H:0]   half_sum;
   logic         wide_ovf;
   logic         half_ovf;

   // subtraction is a + ~b + 1: carry out means no borrow
   assign b_eff    = sub_i ? ~b_i : b_i;
   assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
   assign half_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin_i};

   assign wide_ovf = (a_i[W-1] == b_eff[W-1]) && (wide_sum[W-1] != a_i[W-1]);
   assign half_ovf = (a_i[H-1] == b_eff[H-1]) && (half_sum[H-1] != a_i[H-1]);

   always_comb begin
      if (narrow_i) begin
         sum_o  = {a_i[W-1:H], half_sum[H-1:0]};
         cout_o = half_sum[H];
         ovf_o  = half_ovf;
      end else begin
         sum_o  = wide_sum[W-1:0];
         cout_o = wide_sum[W];
         ovf_o  = wide_ovf;
      end
   end
endmodule

// File: rtl/dwalu_rmw.sv
// Read-modify-write unit: decrement and rotates through carry.
module dwalu_rmw #(
   parameter int W = 16
) (
   input  logic [W-1:0]      src_i,
   input  logic              cin_i,
   input  logic              narrow_i,
   input  dwalu_pkg::alu_op_e op_i,
   output logic [W-1:0]      res_o,
   output logic              cout_o
);
   import dwalu_pkg::*;
   localparam int H = W / 2;

   logic [W-1:0] wide_res;
   logic [H-1:0] half_res;
   logic         wide_c;
   logic         half_c;

   always_comb begin
      wide_res = src_i;
      half_res = src_i[H-1:0];
      wide_c   = cin_i;
      half_c   = cin_i;
      unique case (op_i)
         OP_DEC: begin
            wide_res = src_i - W'(1);
            half_res = src_i[H-1:0] - H'(1);
         end
         OP_ROL: begin
            wide_res = {src_i[W-2:0], cin_i};
            wide_c   = src_i[W-1];
            half_res = {src_i[H-2:0], cin_i};
            half_c   = src_i[H-1];
         end
         OP_ROR: begin
            wide_res = {cin_i, src_i[W-1:1]};
            wide_c   = src_i[0];
            half_res = {cin_i, src_i[H-1:1]};
            half_c   = src_i[0];
         end
         default: ;
      endcase
   end

   assign res_o  = narrow_i ? {src_i[W-1:H], half_res} : wide_res;
   assign cout_o = narrow_i ? half_c : wide_c;
endmodule

// File: rtl/dwalu_nz.sv
// Zero / negative detection at the active width.
module dwalu_nz #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   input  logic         narrow_i,
   output logic         n_o,
   output logic         z_o
);
   localparam int H = W / 2;

   assign n_o = narrow_i ? val_i[H-1] : val_i[W-1];
   assign z_o = narrow_i ? (val_i[H-1:0] == '0) : (val_i == '0);
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_in,
   input  logic [2:0]   op_in,
   input  logic         narrow_in,
   input  logic         to_mem_in,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] mem_in,
   input  logic [3:0]   flags_in,
   output logic         valid_out,
   output logic [W-1:0] acc_out,
   output logic [W-1:0] mem_out,
   output logic         mem_we_out,
   output logic [3:0]   flags_out
);
   import dwalu_pkg::*;
   localparam int H = W / 2;

   if ((W % 2) != 0 || W < 4) begin : g_bad_width
      $error("dual_width_alu: W must be even and at least 4");
   end

   alu_op_e    op;
   alu_flags_t fin;
   assign op  = alu_op_e'(op_in);
   assign fin = alu_flags_t'(flags_in);

   logic rmw_op, mem_tgt, is_cmp;
   assign rmw_op  = (op == OP_DEC) || (op == OP_ROL) || (op == OP_ROR);
   assign mem_tgt = rmw_op && to_mem_in;
   assign is_cmp  = (op == OP_CMP);

   // add / compare
   logic [W-1:0] add_res;
   logic         add_c, add_v;
   dwalu_adder #(.W(W)) u_adder (
      .a_i(acc_in), .b_i(mem_in), .cin_i(is_cmp ? 1'b1 : fin.c),
      .sub_i(is_cmp), .narrow_i(narrow_in),
      .sum_o(add_res), .cout_o(add_c), .ovf_o(add_v)
   );

   // decrement / rotates
   logic [W-1:0] rmw_src, rmw_res;
   logic         rmw_c;
   assign rmw_src = mem_tgt ? mem_in : acc_in;
   dwalu_rmw #(.W(W)) u_rmw (
      .src_i(rmw_src), .cin_i(fin.c), .narrow_i(narrow_in), .op_i(op),
      .res_o(rmw_res), .cout_o(rmw_c)
   );

   // exclusive OR and exchange
   logic [W-1:0] xor_res, xch_res;
   assign xor_res = narrow_in ? {acc_in[W-1:H], acc_in[H-1:0] ^ mem_in[H-1:0]}
                              : (acc_in ^ mem_in);
   assign xch_res = {acc_in[H-1:0], acc_in[W-1:H]};

   logic [W-1:0] nz_src;
   logic         nz_n, nz_z;
   always_comb begin
      unique case (op)
         OP_ADC, OP_CMP: nz_src = add_res;
         OP_EOR:         nz_src = xor_res;
         default:        nz_src = rmw_res;
      endcase
   end
   dwalu_nz #(.W(W)) u_nz (
      .val_i(nz_src), .narrow_i(narrow_in), .n_o(nz_n), .z_o(nz_z)
   );

   logic [W-1:0] acc_nx, mem_nx;
   alu_flags_t   fl_nx;
   always_comb begin
      acc_nx = acc_in;
      mem_nx = mem_in;
      fl_nx  = fin;
      unique case (op)
         OP_ADC: begin
            acc_nx = add_res;
            fl_nx  = '{n: nz_n, z: nz_z, c: add_c, v: add_v};
         end
         OP_CMP: fl_nx = '{n: nz_n, z: nz_z, c: add_c, v: fin.v};
         OP_EOR: begin
            acc_nx  = xor_res;
            fl_nx.n = nz_n;
            fl_nx.z = nz_z;
         end
         OP_DEC, OP_ROL, OP_ROR: begin
            if (mem_tgt) mem_nx = rmw_res;
            else         acc_nx = rmw_res;
            fl_nx.n = nz_n;
            fl_nx.z = nz_z;
            fl_nx.c = rmw_c;
         end
         OP_XCH:  acc_nx = xch_res;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_out  <= 1'b0;
         acc_out    <= '0;
         mem_out    <= '0;
         mem_we_out <= 1'b0;
         flags_out  <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            acc_out    <= acc_nx;
            mem_out    <= mem_nx;
            mem_we_out <= mem_tgt;
            flags_out  <= fl_nx;
         end else begin
            mem_we_out <= 1'b0;
         end
      end
   end

   // R2: outputs hold without a strobe
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> ($stable(acc_out) && $stable(flags_out) && !valid_out));
   // R4: narrow accumulator ops keep the upper byte
   a_r4_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && narrow_in && op_in != 3'd6) |=> acc_out[W-1:H] == $past(acc_in[W-1:H]));
   // R6: compare does not alter the accumulator
   a_r6_cmp_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_in == 3'd1) |=> acc_out == $past(acc_in));
   // R10: exchange swaps halves
   a_r10_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_in == 3'd6) |=>
         (acc_out[W-1:H] == $past(acc_in[H-1:0]) && acc_out[H-1:0] == $past(acc_in[W-1:H])
          && flags_out == $past(flags_in)));
   // R11: overflow flag untouched except by add
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_in != 3'd0) |=> flags_out[0] == $past(flags_in[0]));
   // R12: write enable only alongside a valid result
   a_r12_we_valid: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_out |-> valid_out);
   // R12: memory-targeted ops leave the accumulator alone
   a_r12_mem_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && to_mem_in && op_in >= 3'd3 && op_in <= 3'd5) |=> acc_out == $past(acc_in));
endmodule

// File: tb/dual_width_alu_bench.sv
module dual_width_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [2:0]  op_in = '0;
   logic        narrow_in = 1'b0;
   logic        to_mem_in = 1'b0;
   logic [15:0] acc_in = '0;
   logic [15:0] mem_in = '0;
   logic [3:0]  flags_in = '0;
   logic        valid_out;
   logic [15:0] acc_out;
   logic [15:0] mem_out;
   logic        mem_we_out;
   logic [3:0]  flags_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_width_alu u_dual_width_alu (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_in(op_in),
      .narrow_in(narrow_in), .to_mem_in(to_mem_in), .acc_in(acc_in),
      .mem_in(mem_in), .flags_in(flags_in), .valid_out(valid_out),
      .acc_out(acc_out), .mem_out(mem_out), .mem_we_out(mem_we_out),
      .flags_out(flags_out)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   // expected values
   logic [15:0] e_acc, e_mem;
   logic        e_we;
   logic [3:0]  e_fl;

   task automatic model(input int op, input bit nar, input bit tm, input int a16,
                        input int m16, input logic [3:0] fl);
      int mask, msb, a, b, c, r, s, src;
      bit nn, zz, cc, vv, mem_t;
      mask = nar ? 32'hFF : 32'hFFFF;
      msb  = nar ? 32'h80 : 32'h8000;
      a = a16 & mask; b = m16 & mask; c = int'(fl[1]);
      nn = fl[3]; zz = fl[2]; cc = fl[1]; vv = fl[0];
      e_acc = 16'(a16); e_mem = 16'(m16); e_we = 1'b0;
      mem_t = tm && (op >= 3 && op <= 5);
      src = mem_t ? b : a;
      r = 0;
      case (op)
         0: begin s = a + b + c; r = s & mask; cc = (s > mask);
                  vv = ((a ^ r) & (b ^ r) & msb) != 0; end
         1: begin cc = (a >= b); r = (a - b) & mask; end
         2: r = a ^ b;
         3: r = (src + mask) & mask;
         4: begin r = ((src << 1) | c) & mask; cc = (src & msb) != 0; end
         5: begin r = (src >> 1) | (c ? msb : 0); cc = src[0]; end
         default: ;
      endcase
      if (op <= 5) begin nn = (r & msb) != 0; zz = (r == 0); end
      if (op == 0 || op == 2 || (op >= 3 && op <= 5 && !mem_t))
         e_acc = 16'((a16 & ~mask) | r);
      if (mem_t) begin e_mem = 16'((m16 & ~mask) | r); e_we = 1'b1; end
      if (op == 6) e_acc = {a16[7:0], a16[15:8]};
      e_fl = {nn, zz, cc, vv};
   endtask

   function automatic string tag_of(input int op, input bit nar);
      case (op)
         0: return nar ? "R4" : "R3";
         1: return "R6";
         2: return "R7";
         3: return "R8";
         4, 5: return "R9";
         6: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic run_vec(input int op, input bit nar, input bit tm, input logic [15:0] a,
                          input logic [15:0] m, input logic [3:0] fl);
      string t;
      @(negedge clk);
      op_in = 3'(op); narrow_in = nar; to_mem_in = tm; acc_in = a; mem_in = m;
      flags_in = fl; valid_in = 1'b1;
      model(op, nar, tm, int'(a), int'(m), fl);
      @(negedge clk);
      valid_in = 1'b0;
      t = tag_of(op, nar);
      check("R2", "valid_out", int'(valid_out), 1);
      check(t, "acc_out", int'(acc_out), int'(e_acc));
      check(nar ? "R5" : t, "flag N,Z", int'(flags_out[3:2]), int'(e_fl[3:2]));
      check(t, "flag C", int'(flags_out[1]), int'(e_fl[1]));
      check(op == 0 ? t : "R11", "flag V", int'(flags_out[0]), int'(e_fl[0]));
      check("R12", "mem_we_out", int'(mem_we_out), int'(e_we));
      check(e_we ? "R8" : "R12", "mem_out", int'(mem_out), int'(e_mem));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] vals [10];
      logic [15:0] hold_acc;
      vals = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF,
               16'h7FFF, 16'h8000, 16'hFFFF, 16'h12F0, 16'hA55A};
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "valid_out", int'(valid_out), 0);
      check("R1", "acc_out", int'(acc_out), 0);
      check("R1", "flags_out", int'(flags_out), 0);
      check("R1", "mem_we_out", int'(mem_we_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "acc_out after release", int'(acc_out), 0);

      // R5 explicit: narrow zero with nonzero upper byte
      run_vec(2, 1'b1, 1'b0, 16'hAB3C, 16'h003C, 4'b0000);
      check("R5", "narrow Z on low byte", int'(flags_out[2]), 1);

      // R2 hold: idle cycles keep outputs
      hold_acc = acc_out;
      acc_in = 16'h5555; op_in = 3'd0;
      @(negedge clk);
      check("R2", "valid_out low when idle", int'(valid_out), 0);
      check("R2", "acc_out held", int'(acc_out), int'(hold_acc));

      // sweep
      for (int op = 0; op < 8; op++)
         for (int nar = 0; nar < 2; nar++)
            for (int tm = 0; tm < 2; tm++)
               for (int c = 0; c < 2; c++)
                  for (int i = 0; i < 10; i++)
                     for (int j = 0; j < 10; j++)
                        run_vec(op, nar[0], tm[0], vals[i], vals[j],
                                {(i[0] ^ j[1]), j[0], c[0], (i[1] ^ c[0])});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule